// File: doc/BRIEF.md
# I/O Port Space Router

The router takes an I/O-port address and the direction of the access and decides which of four programmable windows claims it. Each window has a base word and a limit word. Together they give a page range at 4 KB granularity, read and write permissions, a destination node and a destination link. A lookup returns whether some window claimed the access, and if so the node, the link and the number of the winning window.

Two legacy rules sit on top of the page compare, and each window enables them on its own. The display-adapter rule claims the classic monochrome and colour adapter port blocks in the first 64 KB of port space, whatever the page range says. The expansion-bus rule removes the upper three quarters of every 1 KB block in that same 64 KB region from the page compare only. Software programs the windows through a small word-wide register port. Lookups are presented one per cycle on a separate port and answered one cycle later.

Top module: `io_port_router`

## Requirements
- R1: After reset every window word reads zero, no lookup result or read data is flagged valid, and every lookup misses.
- R2: Register address `cfg_addr` = {window index, select}, where select 0 is the base word and select 1 is the limit word. A write changes lookups from the next cycle on. Read data appears with `cfg_rvalid` exactly one cycle after `cfg_rd_en`.
- R3: Base word layout: bit 0 read permit, bit 1 write permit, bit 4 display-adapter rule, bit 5 expansion-bus rule, bits [24:12] base page. Limit word layout: bits [2:0] node, bits [5:4] link, bits [24:12] limit page. Every other bit is discarded on write and reads as zero, so all-ones writes read back as 0x01FFF033 (base) and 0x01FFF037 (limit).
- R4: The page compare holds when base page ≤ address[24:12] ≤ limit page. Both ends are inclusive.
- R5: A window claims a read only when its read permit is set, and a write only when its write permit is set. This applies to every kind of match.
- R6: With the display-adapter rule on, an address below 0x10000 whose bits [9:0] lie in 0x3B0–0x3BB or 0x3C0–0x3DF matches the window, independent of its pages and of its expansion-bus rule. Addresses at or above 0x10000 never match this way.
- R7: With the expansion-bus rule on, an address below 0x10000 whose bits [9:8] are not 00 cannot match that window through the page compare. Addresses at or above 0x10000, and windows with the rule off, are unaffected.
- R8: When several windows claim an access, the lowest-numbered one wins, and its node, link and index are reported.
- R9: On a miss, `res_hit` is 0 and `res_node`, `res_link` and `res_idx` are all 0.
- R10: A window whose link field holds the reserved code 3 never claims any access.
- R11: `res_valid` rises exactly one cycle after each `lk_valid` and at no other time. `res_hit` is only ever 1 together with `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_addr | input | 3 | {window index, select} |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, reserved bits zero |
| cfg_rvalid | output | 1 | Read data valid |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 25 | I/O-port address to route |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Some window claimed the access |
| res_node | output | 3 | Destination node of the winner |
| res_link | output | 2 | Destination link of the winner |
| res_idx | output | 2 | Index of the winning window |

## Verification
Every lookup result is due one clock edge after the cycle that carries `lk_valid`, and every register read is due one edge after `cfg_rd_en`. A register write affects lookups from the following cycle. The driver queues the expected outcome when it presents a stimulus. The monitor compares on the falling edge after the next rising edge and pops one entry for each valid flag it sees. A valid flag with an empty queue counts as a miscompare, and so does an entry still queued at the end, so a result that is early, late or missing is reported.

// File: rtl/iort_pkg.sv
package iort_pkg;

    localparam int NODE_W = 3;
    localparam int LINK_W = 2;

    // Field positions inside the window words
    localparam int BASE_RD_BIT  = 0;
    localparam int BASE_WR_BIT  = 1;
    localparam int BASE_VGA_BIT = 4;
    localparam int BASE_ISA_BIT = 5;
    localparam int LIM_NODE_LSB = 0;
    localparam int LIM_LINK_LSB = 4;

    localparam logic [LINK_W-1:0] LINK_RESERVED = 2'b11;

    typedef struct packed {
        logic              rd_ok;
        logic              wr_ok;
        logic              vga_on;
        logic              isa_on;
        logic [NODE_W-1:0] node;
        logic [LINK_W-1:0] link;
    } win_ctl_t;

endpackage

// File: rtl/iort_regfile.sv
module iort_regfile
    import iort_pkg::*;
#(
    parameter  int NUM_WIN  = 4,
    parameter  int ADDR_W   = 25,
    parameter  int PAGE_LSB = 12,
    parameter  int DATA_W   = 32,
    localparam int IDX_W    = $clog2(NUM_WIN),
    localparam int CFG_AW   = IDX_W + 1,
    localparam int PAGE_W   = ADDR_W - PAGE_LSB
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_wr_en,
    input  logic                             cfg_rd_en,
    input  logic [CFG_AW-1:0]                cfg_addr,
    input  logic [DATA_W-1:0]                cfg_wdata,
    output logic [DATA_W-1:0]                cfg_rdata,
    output logic                             cfg_rvalid,
    output win_ctl_t [NUM_WIN-1:0]           ctl,
    output logic [NUM_WIN-1:0][PAGE_W-1:0]   base_pg,
    output logic [NUM_WIN-1:0][PAGE_W-1:0]   limit_pg
);

    logic             wr_sel;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [DATA_W-1:0] rd_word;

    assign wr_sel = cfg_addr[0];
    assign wr_idx = cfg_addr[CFG_AW-1:1];
    assign rd_idx = cfg_addr[CFG_AW-1:1];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctl[w]      <= '0;
                base_pg[w]  <= '0;
                limit_pg[w] <= '0;
            end else if (cfg_wr_en && (wr_idx == IDX_W'(w))) begin
                if (!wr_sel) begin
                    ctl[w].rd_ok  <= cfg_wdata[BASE_RD_BIT];
                    ctl[w].wr_ok  <= cfg_wdata[BASE_WR_BIT];
                    ctl[w].vga_on <= cfg_wdata[BASE_VGA_BIT];
                    ctl[w].isa_on <= cfg_wdata[BASE_ISA_BIT];
                    base_pg[w]    <= cfg_wdata[PAGE_LSB +: PAGE_W];
                end else begin
                    ctl[w].node   <= cfg_wdata[LIM_NODE_LSB +: NODE_W];
                    ctl[w].link   <= cfg_wdata[LIM_LINK_LSB +: LINK_W];
                    limit_pg[w]   <= cfg_wdata[PAGE_LSB +: PAGE_W];
                end
            end
        end
    end

    // Read word assembly: reserved bits stay zero
    always_comb begin
        rd_word = '0;
        if (!cfg_addr[0]) begin
            rd_word[BASE_RD_BIT]          = ctl[rd_idx].rd_ok;
            rd_word[BASE_WR_BIT]          = ctl[rd_idx].wr_ok;
            rd_word[BASE_VGA_BIT]         = ctl[rd_idx].vga_on;
            rd_word[BASE_ISA_BIT]         = ctl[rd_idx].isa_on;
            rd_word[PAGE_LSB +: PAGE_W]   = base_pg[rd_idx];
        end else begin
            rd_word[LIM_NODE_LSB +: NODE_W] = ctl[rd_idx].node;
            rd_word[LIM_LINK_LSB +: LINK_W] = ctl[rd_idx].link;
            rd_word[PAGE_LSB +: PAGE_W]     = limit_pg[rd_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rvalid <= 1'b0;
            cfg_rdata  <= '0;
        end else begin
            cfg_rvalid <= cfg_rd_en;
            if (cfg_rd_en) begin
                cfg_rdata <= rd_word;
            end
        end
    end

endmodule

// File: rtl/iort_win_match.sv
module iort_win_match
    import iort_pkg::*;
#(
    parameter  int ADDR_W      = 25,
    parameter  int PAGE_LSB    = 12,
    parameter  int LEGACY_BITS = 16,
    localparam int PAGE_W      = ADDR_W - PAGE_LSB
) (
    input  win_ctl_t            ctl,
    input  logic [PAGE_W-1:0]   base_pg,
    input  logic [PAGE_W-1:0]   limit_pg,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                is_write,
    output logic                match
);

    localparam logic [9:0] MONO_LO  = 10'h3B0;
    localparam logic [9:0] MONO_HI  = 10'h3BB;
    localparam logic [9:0] COLOR_LO = 10'h3C0;
    localparam logic [9:0] COLOR_HI = 10'h3DF;

    logic              legacy_zone;
    logic [9:0]        port_lo;
    logic [PAGE_W-1:0] page;
    logic              permitted;
    logic              in_pages;
    logic              isa_hole;
    logic              vga_port;

    assign legacy_zone = (addr[ADDR_W-1:LEGACY_BITS] == '0);
    assign port_lo     = addr[9:0];
    assign page        = addr[ADDR_W-1:PAGE_LSB];

    assign permitted = is_write ? ctl.wr_ok : ctl.rd_ok;
    assign in_pages  = (page >= base_pg) && (page <= limit_pg);
    assign isa_hole  = ctl.isa_on && legacy_zone && (port_lo[9:8] != 2'b00);
    assign vga_port  = ctl.vga_on && legacy_zone &&
                       (((port_lo >= MONO_LO)  && (port_lo <= MONO_HI)) ||
                        ((port_lo >= COLOR_LO) && (port_lo <= COLOR_HI)));

    assign match = permitted && (ctl.link != LINK_RESERVED) &&
                   (vga_port || (in_pages && !isa_hole));

endmodule

// File: rtl/iort_prio_pick.sv
module iort_prio_pick #(
    parameter  int NUM_WIN = 4,
    localparam int IDX_W   = $clog2(NUM_WIN)
) (
    input  logic [NUM_WIN-1:0] req,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        found = |req;
        idx   = '0;
        for (int k = NUM_WIN - 1; k >= 0; k--) begin
            if (req[k]) begin
                idx = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/io_port_router.sv
module io_port_router
    import iort_pkg::*;
#(
    parameter  int NUM_WIN     = 4,
    parameter  int ADDR_W      = 25,
    parameter  int PAGE_LSB    = 12,
    parameter  int LEGACY_BITS = 16,
    parameter  int DATA_W      = 32,
    localparam int IDX_W       = $clog2(NUM_WIN),
    localparam int CFG_AW      = IDX_W + 1,
    localparam int PAGE_W      = ADDR_W - PAGE_LSB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic               cfg_rd_en,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    output logic [DATA_W-1:0]  cfg_rdata,
    output logic               cfg_rvalid,
    input  logic               lk_valid,
    input  logic [ADDR_W-1:0]  lk_addr,
    input  logic               lk_write,
    output logic               res_valid,
    output logic               res_hit,
    output logic [NODE_W-1:0]  res_node,
    output logic [LINK_W-1:0]  res_link,
    output logic [IDX_W-1:0]   res_idx
);

    win_ctl_t [NUM_WIN-1:0]         ctl;
    logic [NUM_WIN-1:0][PAGE_W-1:0] base_pg;
    logic [NUM_WIN-1:0][PAGE_W-1:0] limit_pg;
    logic [NUM_WIN-1:0]             claim;
    logic                           any_claim;
    logic [IDX_W-1:0]               win_idx;

    iort_regfile #(
        .NUM_WIN  (NUM_WIN),
        .ADDR_W   (ADDR_W),
        .PAGE_LSB (PAGE_LSB),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_rd_en  (cfg_rd_en),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .cfg_rvalid (cfg_rvalid),
        .ctl        (ctl),
        .base_pg    (base_pg),
        .limit_pg   (limit_pg)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
        iort_win_match #(
            .ADDR_W      (ADDR_W),
            .PAGE_LSB    (PAGE_LSB),
            .LEGACY_BITS (LEGACY_BITS)
        ) u_match (
            .ctl      (ctl[w]),
            .base_pg  (base_pg[w]),
            .limit_pg (limit_pg[w]),
            .addr     (lk_addr),
            .is_write (lk_write),
            .match    (claim[w])
        );
    end

    iort_prio_pick #(
        .NUM_WIN (NUM_WIN)
    ) u_pick (
        .req   (claim),
        .found (any_claim),
        .idx   (win_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_node  <= '0;
            res_link  <= '0;
            res_idx   <= '0;
        end else begin
            res_valid <= lk_valid;
            res_hit   <= lk_valid && any_claim;
            if (lk_valid && any_claim) begin
                res_node <= ctl[win_idx].node;
                res_link <= ctl[win_idx].link;
                res_idx  <= win_idx;
            end else begin
                res_node <= '0;
                res_link <= '0;
                res_idx  <= '0;
            end
        end
    end

endmodule

// File: rtl/iort_chk.sv
module iort_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_rd_en,
    input logic        cfg_rvalid,
    input logic [31:0] cfg_rdata,
    input logic        lk_valid,
    input logic        res_valid,
    input logic        res_hit,
    input logic [2:0]  res_node,
    input logic [1:0]  res_link,
    input logic [1:0]  res_idx
);

    a_r2_read_due: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_en |=> cfg_rvalid);

    a_r2_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd_en |=> !cfg_rvalid);

    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rvalid |-> ((cfg_rdata & 32'hFE00_0FC8) == 32'h0));

    a_r11_result_due: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    a_r11_result_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    a_r11_hit_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_valid);

    a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |->
            (res_node == 3'd0 && res_link == 2'd0 && res_idx == 2'd0));

    a_r10_no_reserved_link: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> (res_link != 2'b11));

endmodule

bind io_port_router iort_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_rd_en  (cfg_rd_en),
    .cfg_rvalid (cfg_rvalid),
    .cfg_rdata  (cfg_rdata),
    .lk_valid   (lk_valid),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_node   (res_node),
    .res_link   (res_link),
    .res_idx    (res_idx)
);

// File: tb/sim_io_port_router.sv
module sim_io_port_router;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_rd_en = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_rvalid;
    logic        lk_valid = 1'b0;
    logic [24:0] lk_addr = '0;
    logic        lk_write = 1'b0;
    logic        res_valid;
    logic        res_hit;
    logic [2:0]  res_node;
    logic [1:0]  res_link;
    logic [1:0]  res_idx;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [7:0]  lk_exp_q[$];
    string       lk_tag_q[$];
    logic [31:0] rd_exp_q[$];
    string       rd_tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    io_port_router u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_rd_en  (cfg_rd_en),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .cfg_rvalid (cfg_rvalid),
        .lk_valid   (lk_valid),
        .lk_addr    (lk_addr),
        .lk_write   (lk_write),
        .res_valid  (res_valid),
        .res_hit    (res_hit),
        .res_node   (res_node),
        .res_link   (res_link),
        .res_idx    (res_idx)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Driver tasks: present stimulus on a falling edge and queue the expectation
    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_rd_en = 1'b1; cfg_addr = a;
        rd_exp_q.push_back(exp);
        rd_tag_q.push_back(tag);
        @(negedge clk);
        cfg_rd_en = 1'b0;
    endtask

    task automatic lookup(input logic [24:0] a, input bit wr, input bit hit,
                          input logic [2:0] node, input logic [1:0] link,
                          input logic [1:0] idx, input string tag);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a; lk_write = wr;
        lk_exp_q.push_back({hit, node, link, idx});
        lk_tag_q.push_back(tag);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    // Monitor: compare each flagged result against the oldest expectation
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (res_valid) begin
                if (lk_exp_q.size() == 0) begin
                    check(1'b0, "R11 unexpected result", {24'h0, res_hit, res_node, res_link, res_idx}, 32'h0);
                end else begin
                    automatic logic [7:0] e = lk_exp_q.pop_front();
                    automatic string t = lk_tag_q.pop_front();
                    check({res_hit, res_node, res_link, res_idx} == e, t,
                          {24'h0, res_hit, res_node, res_link, res_idx}, {24'h0, e});
                end
            end
            if (cfg_rvalid) begin
                if (rd_exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected read data", cfg_rdata, 32'h0);
                end else begin
                    automatic logic [31:0] e = rd_exp_q.pop_front();
                    automatic string t = rd_tag_q.pop_front();
                    check(cfg_rdata == e, t, cfg_rdata, e);
                end
            end
        end
    end

    task automatic finish_run();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog expired", 32'h0, 32'h0);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_valid == 1'b0, "R1 res_valid after reset", {31'h0, res_valid}, 32'h0);
        check(cfg_rvalid == 1'b0, "R1 cfg_rvalid after reset", {31'h0, cfg_rvalid}, 32'h0);
        cfg_read(3'd0, 32'h0, "R1 base0 reset value");
        cfg_read(3'd7, 32'h0, "R1 limit3 reset value");
        lookup(25'h01000, 1'b0, 1'b0, 3'd0, 2'd0, 2'd0, "R1 lookup after reset misses");

        // R3: reserved bits dropped
        cfg_write(3'd6, 32'hFFFF_FFFF);
        cfg_write(3'd7, 32'hFFFF_FFFF);
        cfg_read(3'd6, 32'h01FF_F033, "R3 base all-ones readback");
        cfg_read(3'd7, 32'h01FF_F037, "R3 limit all-ones readback");

        // R10: reserved link code disables the window
        cfg_write(3'd0, 32'h0000_0003);
        cfg_write(3'd1, 32'h01FF_F037);
        lookup(25'h05000, 1'b0, 1'b0, 3'd0, 2'd0, 2'd0, "R10 link 3 never claims");
        cfg_write(3'd1, 32'h01FF_F025);
        lookup(25'h05000, 1'b0, 1'b1, 3'd5, 2'd2, 2'd0, "R10 valid link claims");

        // Main configuration
        cfg_write(3'd0, 32'h0001_0021); // win0: pages 0x10..0x1F, read only, bus rule
        cfg_write(3'd1, 32'h0001_F012); // node 2 link 1
        cfg_write(3'd2, 32'h0001_8003); // win1: pages 0x18..0x30, read+write
        cfg_write(3'd3, 32'h0003_0021); // node 1 link 2
        cfg_write(3'd4, 32'h0000_0023); // win2: pages 0..3, read+write, bus rule
        cfg_write(3'd5, 32'h0000_3004); // node 4 link 0
        cfg_write(3'd6, 32'h0000_0012); // win3: page 0, write only, adapter rule
        cfg_write(3'd7, 32'h0000_0017); // node 7 link 1

        cfg_read(3'd3, 32'h0003_0021, "R2 limit1 readback");
        cfg_read(3'd0, 32'h0001_0021, "R2 base0 readback");

        lookup(25'h12345, 1'b0, 1'b1, 3'd2, 2'd1, 2'd0, "R4 R7 range hit above 64K");
        lookup(25'h12345, 1'b1, 1'b0, 3'd0, 2'd0, 2'd0, "R5 write without permit");
        lookup(25'h1A000, 1'b0, 1'b1, 3'd2, 2'd1, 2'd0, "R8 lowest index wins");
        lookup(25'h1A000, 1'b1, 1'b1, 3'd1, 2'd2, 2'd1, "R8 R5 write falls to win1");
        lookup(25'h30FFF, 1'b0, 1'b1, 3'd1, 2'd2, 2'd1, "R4 limit inclusive");
        lookup(25'h31000, 1'b0, 1'b0, 3'd0, 2'd0, 2'd0, "R4 R9 past limit misses");
        lookup(25'h18000, 1'b1, 1'b1, 3'd1, 2'd2, 2'd1, "R4 base inclusive");
        lookup(25'h17FFF, 1'b1, 1'b0, 3'd0, 2'd0, 2'd0, "R4 below base misses");

        lookup(25'h00100, 1'b0, 1'b0, 3'd0, 2'd0, 2'd0, "R7 hole blocks range");
        lookup(25'h00050, 1'b0, 1'b1, 3'd4, 2'd0, 2'd2, "R7 low quarter passes");
        lookup(25'h02C10, 1'b0, 1'b1, 3'd4, 2'd0, 2'd2, "R7 low quarter passes page 2");
        lookup(25'h02F10, 1'b0, 1'b0, 3'd0, 2'd0, 2'd0, "R7 upper quarter blocked");
        lookup(25'h00100, 1'b1, 1'b1, 3'd7, 2'd1, 2'd3, "R7 rule is per window");

        lookup(25'h003C5, 1'b0, 1'b0, 3'd0, 2'd0, 2'd0, "R6 R5 adapter match needs permit");
        lookup(25'h0F3B4, 1'b1, 1'b1, 3'd7, 2'd1, 2'd3, "R6 mono block bypasses range");
        lookup(25'h0F3B4, 1'b0, 1'b0, 3'd0, 2'd0, 2'd0, "R6 R5 read not permitted");
        lookup(25'h0F3BB, 1'b1, 1'b1, 3'd7, 2'd1, 2'd3, "R6 mono top edge");
        lookup(25'h0F3BC, 1'b1, 1'b0, 3'd0, 2'd0, 2'd0, "R6 just past mono");
        lookup(25'h0F3AF, 1'b1, 1'b0, 3'd0, 2'd0, 2'd0, "R6 just below mono");
        lookup(25'h0F3C0, 1'b1, 1'b1, 3'd7, 2'd1, 2'd3, "R6 colour low edge");
        lookup(25'h0F3DF, 1'b1, 1'b1, 3'd7, 2'd1, 2'd3, "R6 colour top edge");
        lookup(25'h0F3E0, 1'b1, 1'b0, 3'd0, 2'd0, 2'd0, "R6 just past colour");
        lookup(25'h403B4, 1'b1, 1'b0, 3'd0, 2'd0, 2'd0, "R6 above 64K no adapter match");

        cfg_write(3'd4, 32'h0000_0033); // win2 adapter rule on
        lookup(25'h003C5, 1'b0, 1'b1, 3'd4, 2'd0, 2'd2, "R6 adapter overrides bus hole");

        repeat (3) @(negedge clk);
        check(lk_exp_q.size() == 0, "R11 lookup results outstanding", lk_exp_q.size(), 32'h0);
        check(rd_exp_q.size() == 0, "R2 read results outstanding", rd_exp_q.size(), 32'h0);
        finish_run();
    end

endmodule